// File: doc/BRIEF.md
# Multiple Charge Transfer Row Controller

This block sequences the control pins of an image sensor pixel array in which each pixel may move its photodiode charge onto an enlarged storage node more than once per frame. A frame visits the rows one after another, from row 0 up to the last row. For every row the transfer gate is pulsed N times in total. N−1 of those pulses come while the row is still deselected, spaced by a programmable interval so that the photodiode is emptied before it can overflow. The last pulse comes inside the row's select window. In that window the charge is transferred before the pixel is reset, which allows a delta reset sample: transfer, signal sample, pixel reset, reset sample.

When the reset sample ends, a one-clock start is sent to the column readout. The row stays selected until the readout answers with a done pulse. After the last row a frame-done pulse is given and the controller idles until the next frame start. The transfer count and the three timing lengths are captured when a frame starts and hold for the whole frame. Control pins are plain levels and pulses. The readout link is a start/done pair. No back-pressure exists apart from the controller waiting for done, for as long as the readout needs.

Top module: `mct_row_ctrl`

## Requirements
- R1: While reset is held and after it is released with no frame start, `row_sel`, `xfer_gate`, `sig_sample`, `pix_reset`, `rst_sample`, `col_start` and `frame_done` are low and `row_idx` is 0.
- R2: A frame start accepted while idle selects the rows in ascending order, starting at 0 and stepping by one, up to ROWS−1. Each row gets exactly one select window, and `row_idx` is stable while `row_sel` is high.
- R3: The 2-bit `xfer_count` gives N, with code 0 treated as 1. Before each select window, `xfer_gate` pulses exactly N−1 times with `row_sel` low, and no other strobe occurs while `row_sel` is low.
- R4: A pre-select transfer pulse is followed by exactly `xfer_gap` low clocks (0 treated as 1) before the next pre-select pulse or, after the last one, before `row_sel` rises.
- R5: Inside each select window the strobes come in the fixed order `xfer_gate`, `sig_sample`, `pix_reset`, `rst_sample`, `col_start`, each exactly once. This order is the same for every N.
- R6: At most one of `xfer_gate`, `sig_sample`, `pix_reset`, `rst_sample` is high in any clock. Exactly `strobe_gap` idle clocks (0 treated as 1) separate the rise of `row_sel` from the transfer pulse, and separate each strobe in the window from the next.
- R7: Every transfer, sample and reset pulse is high for exactly `pulse_len` clocks (0 treated as 1).
- R8: `col_start` is high for one clock, in the clock right after the last `rst_sample` clock. `row_sel` then stays high and the row holds until `col_done` is seen; `col_done` may arrive in the same clock as `col_start`. `row_sel` falls in the clock after `col_done`.
- R9: Between two rows of a frame, `row_sel` and all strobes stay low for exactly `strobe_gap` clocks before the next row's first transfer pulse or select window.
- R10: `frame_done` is a one-clock pulse, given in the clock after `col_done` of the last row with `row_sel` low. The controller then stays idle, with no strobes, until a new frame start.
- R11: A frame start that arrives while a frame is in progress is ignored: the running frame goes on with its row order unchanged and is not restarted.
- R12: `xfer_count`, `pulse_len`, `strobe_gap` and `xfer_gap` are captured at the accepted frame start. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a frame when the controller is idle |
| xfer_count | input | 2 | Transfers per row N (0 treated as 1) |
| pulse_len | input | TW | Width of every strobe in clocks |
| strobe_gap | input | TW | Idle clocks between strobes and between rows |
| xfer_gap | input | TW | Low clocks after each pre-select transfer pulse |
| col_done | input | 1 | Column readout has finished the current row |
| row_idx | output | RW | Index of the row being driven |
| row_sel | output | 1 | Row select |
| xfer_gate | output | 1 | Transfer gate pulse |
| sig_sample | output | 1 | Signal sample strobe |
| pix_reset | output | 1 | Pixel reset pulse |
| rst_sample | output | 1 | Reset sample strobe |
| col_start | output | 1 | One-clock start for the column readout |
| frame_done | output | 1 | One-clock pulse after the last row |

## Verification
Two pairs of events can land in the same clock: the readout's done with the controller's own start, and a new frame start with a frame that is still running. The first pair is provoked by a readout model that answers with zero latency, so `col_done` is high in the `col_start` clock. It is judged by checking that `row_sel` falls in the very next clock, and that no row is skipped or repeated. The second pair is provoked by pulsing `frame_start` mid-frame while changing the count and the timing inputs. It is judged by the row order, the transfer counts and the pulse widths, which must still follow the values captured at the accepted start.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM,
    ST_PRE_TX,
    ST_PRE_GAP,
    ST_SEL_GAP,
    ST_TX,
    ST_GAP1,
    ST_PSIG,
    ST_GAP2,
    ST_RST,
    ST_GAP3,
    ST_PRST,
    ST_KICK,
    ST_WAIT,
    ST_ROW_GAP,
    ST_DONE
  } phase_t;

endpackage

// File: rtl/mct_timer.sv
module mct_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/mct_row_counter.sv
module mct_row_counter #(
  parameter int ROWS = 3000,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [RW-1:0] row,
  output logic          last
);

  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (clr)  row <= '0;
    else if (inc)  row <= row + 1'b1;
  end

  assign last = (row == LAST_ROW);

  a_r2_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    row <= LAST_ROW);

endmodule

// File: rtl/mct_seq.sv
module mct_seq
  import mct_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    n_cfg,
  input  logic [TW-1:0] pw,
  input  logic [TW-1:0] gw,
  input  logic [TW-1:0] iw,
  input  logic          t_done,
  input  logic          col_done,
  input  logic          row_last,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          cfg_cap,
  output logic          row_clr,
  output logic          row_inc,
  output logic          row_sel,
  output logic          xfer_gate,
  output logic          sig_sample,
  output logic          pix_reset,
  output logic          rst_sample,
  output logic          col_start,
  output logic          frame_done
);

  phase_t     state_q, state_d;
  logic [1:0] pre_q;
  logic       pre_inc, pre_clr;

  logic [TW-1:0] pw_m1, gw_m1, iw_m1;
  assign pw_m1 = pw - 1'b1;
  assign gw_m1 = gw - 1'b1;
  assign iw_m1 = iw - 1'b1;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    cfg_cap = 1'b0;
    row_clr = 1'b0;
    row_inc = 1'b0;
    pre_inc = 1'b0;
    pre_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ARM; cfg_cap = 1'b1; row_clr = 1'b1; pre_clr = 1'b1;
        t_load = 1'b1;
      end
      ST_ARM: begin
        t_load = 1'b1;
        if (n_cfg > 2'd1) begin state_d = ST_PRE_TX;  t_val = pw_m1; end
        else              begin state_d = ST_SEL_GAP; t_val = gw_m1; end
      end
      ST_PRE_TX: if (t_done) begin
        state_d = ST_PRE_GAP; t_load = 1'b1; t_val = iw_m1; pre_inc = 1'b1;
      end
      ST_PRE_GAP: if (t_done) begin
        t_load = 1'b1;
        if (pre_q == n_cfg - 2'd1) begin state_d = ST_SEL_GAP; t_val = gw_m1; end
        else                       begin state_d = ST_PRE_TX;  t_val = pw_m1; end
      end
      ST_SEL_GAP: if (t_done) begin state_d = ST_TX;   t_load = 1'b1; t_val = pw_m1; end
      ST_TX:      if (t_done) begin state_d = ST_GAP1; t_load = 1'b1; t_val = gw_m1; end
      ST_GAP1:    if (t_done) begin state_d = ST_PSIG; t_load = 1'b1; t_val = pw_m1; end
      ST_PSIG:    if (t_done) begin state_d = ST_GAP2; t_load = 1'b1; t_val = gw_m1; end
      ST_GAP2:    if (t_done) begin state_d = ST_RST;  t_load = 1'b1; t_val = pw_m1; end
      ST_RST:     if (t_done) begin state_d = ST_GAP3; t_load = 1'b1; t_val = gw_m1; end
      ST_GAP3:    if (t_done) begin state_d = ST_PRST; t_load = 1'b1; t_val = pw_m1; end
      ST_PRST:    if (t_done) begin state_d = ST_KICK; t_load = 1'b1; end
      ST_KICK, ST_WAIT: begin
        if (col_done) begin
          t_load = 1'b1;
          if (row_last) state_d = ST_DONE;
          else begin state_d = ST_ROW_GAP; t_val = gw_m1; row_inc = 1'b1; end
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_ROW_GAP: if (t_done) begin
        t_load = 1'b1; pre_clr = 1'b1;
        if (n_cfg > 2'd1) begin state_d = ST_PRE_TX;  t_val = pw_m1; end
        else              begin state_d = ST_SEL_GAP; t_val = gw_m1; end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
    end else begin
      state_q <= state_d;
      if (pre_clr)      pre_q <= '0;
      else if (pre_inc) pre_q <= pre_q + 1'b1;
    end
  end

  assign row_sel    = state_q inside {ST_SEL_GAP, ST_TX, ST_GAP1, ST_PSIG, ST_GAP2,
                                      ST_RST, ST_GAP3, ST_PRST, ST_KICK, ST_WAIT};
  assign xfer_gate  = (state_q == ST_PRE_TX) || (state_q == ST_TX);
  assign sig_sample = (state_q == ST_PSIG);
  assign pix_reset  = (state_q == ST_RST);
  assign rst_sample = (state_q == ST_PRST);
  assign col_start  = (state_q == ST_KICK);
  assign frame_done = (state_q == ST_DONE);

  logic [3:0] strb;
  assign strb = {xfer_gate, sig_sample, pix_reset, rst_sample};

  // R6: never two strobes together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  // R6: a strobe may not be followed directly by a different strobe
  a_r6_idle_between: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb && |$past(strb)) |-> (strb == $past(strb)));

  // R3/R5: only the transfer gate may fire outside the select window
  a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_sample || pix_reset || rst_sample || col_start) |-> row_sel);

  // R8: start lasts one clock and follows the reset sample
  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    col_start |=> !col_start);
  a_r8_start_after_prst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_sample) |-> col_start);

  // R8: row held until the readout answers
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel && !xfer_gate && !sig_sample && !pix_reset && !rst_sample
     && !col_start && !col_done && $past(col_start || !sig_sample)) |=> row_sel);

  // R10: frame done is one clock with the row deselected
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!row_sel ##1 !frame_done));

endmodule

// File: rtl/mct_row_ctrl.sv
module mct_row_ctrl
  import mct_pkg::*;
#(
  parameter int ROWS = 3000,
  parameter int TW   = 8,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [1:0]    xfer_count,
  input  logic [TW-1:0] pulse_len,
  input  logic [TW-1:0] strobe_gap,
  input  logic [TW-1:0] xfer_gap,
  input  logic          col_done,
  output logic [RW-1:0] row_idx,
  output logic          row_sel,
  output logic          xfer_gate,
  output logic          sig_sample,
  output logic          pix_reset,
  output logic          rst_sample,
  output logic          col_start,
  output logic          frame_done
);

  logic [1:0]    n_q;
  logic [TW-1:0] pw_q, gw_q, iw_q;
  logic          cfg_cap, t_load, t_done, row_clr, row_inc, row_last;
  logic [TW-1:0] t_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q  <= 2'd1;
      pw_q <= TW'(1);
      gw_q <= TW'(1);
      iw_q <= TW'(1);
    end else if (cfg_cap) begin
      n_q  <= (xfer_count == 2'd0) ? 2'd1   : xfer_count;
      pw_q <= (pulse_len  == '0)   ? TW'(1) : pulse_len;
      gw_q <= (strobe_gap == '0)   ? TW'(1) : strobe_gap;
      iw_q <= (xfer_gap   == '0)   ? TW'(1) : xfer_gap;
    end
  end

  mct_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  mct_row_counter #(.ROWS(ROWS)) u_rows (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (row_clr),
    .inc   (row_inc),
    .row   (row_idx),
    .last  (row_last)
  );

  mct_seq #(.TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .n_cfg      (n_q),
    .pw         (pw_q),
    .gw         (gw_q),
    .iw         (iw_q),
    .t_done     (t_done),
    .col_done   (col_done),
    .row_last   (row_last),
    .t_load     (t_load),
    .t_val      (t_val),
    .cfg_cap    (cfg_cap),
    .row_clr    (row_clr),
    .row_inc    (row_inc),
    .row_sel    (row_sel),
    .xfer_gate  (xfer_gate),
    .sig_sample (sig_sample),
    .pix_reset  (pix_reset),
    .rst_sample (rst_sample),
    .col_start  (col_start),
    .frame_done (frame_done)
  );

  // R2: the row index does not move inside a select window
  a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel && $past(row_sel)) |-> $stable(row_idx));

  // R12: captured transfer count stays legal
  a_r12_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q != 2'd0));

endmodule

// File: tb/mct_row_ctrl_test.sv
`timescale 1ns/1ps
module mct_row_ctrl_test;

  localparam int ROWS = 5;
  localparam int TW   = 8;
  localparam int RW   = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [1:0]    xfer_count = 2'd1;
  logic [TW-1:0] pulse_len = 8'd1, strobe_gap = 8'd1, xfer_gap = 8'd1;
  logic          col_done = 1'b0;
  logic [RW-1:0] row_idx;
  logic row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start, frame_done;

  always #2.5 clk = ~clk;

  mct_row_ctrl #(.ROWS(ROWS), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .xfer_count(xfer_count),
    .pulse_len(pulse_len), .strobe_gap(strobe_gap), .xfer_gap(xfer_gap),
    .col_done(col_done), .row_idx(row_idx), .row_sel(row_sel), .xfer_gate(xfer_gate),
    .sig_sample(sig_sample), .pix_reset(pix_reset), .rst_sample(rst_sample),
    .col_start(col_start), .frame_done(frame_done)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected frame configuration, computed by the bench
  bit mon_en = 0;
  int m_n, m_pw, m_gw, m_iw, lat;
  int prev_code, run_len, idle_len, seq_idx, pre_cnt, exp_row, rows_seen;
  int rowgap_cnt, done_cnt, wait_cnt;
  bit rowgap_flag, prev_sel;
  logic [RW-1:0] prev_row;

  function automatic int code_of();
    if (xfer_gate)  return 1;
    if (sig_sample) return 2;
    if (pix_reset)  return 3;
    if (rst_sample) return 4;
    if (col_start)  return 5;
    return 0;
  endfunction

  always @(negedge clk) begin
    int cur;
    if (mon_en) begin
      cur = code_of();
      chk($countones({xfer_gate, sig_sample, pix_reset, rst_sample}) <= 1,
          "R6", "strobes overlap", $countones({xfer_gate, sig_sample, pix_reset, rst_sample}), 1);
      if (cur != 0 && prev_code != 0 && cur != prev_code && !(prev_code == 4 && cur == 5))
        chk(0, "R6", "no idle clock between strobes", cur, prev_code);
      if (row_sel && prev_sel && row_idx != prev_row)
        chk(0, "R2", "row moved inside window", row_idx, prev_row);
      // pulse falls
      if (prev_code != 0 && cur != prev_code)
        chk(run_len == ((prev_code == 5) ? 1 : m_pw), (prev_code == 5) ? "R8" : "R7",
            "pulse width", run_len, (prev_code == 5) ? 1 : m_pw);
      // select rise
      if (row_sel && !prev_sel) begin
        chk(row_idx == exp_row, "R2", "row order", row_idx, exp_row);
        chk(pre_cnt == m_n - 1, "R3", "pre-select transfers", pre_cnt, m_n - 1);
        if (m_n > 1) chk(idle_len == m_iw, "R4", "gap before select", idle_len, m_iw);
        else if (rowgap_flag) chk(rowgap_cnt == m_gw, "R9", "row gap", rowgap_cnt, m_gw);
        rowgap_flag = 0;
        seq_idx = 0;
        idle_len = 0;
      end
      // strobe rises
      if (cur != 0 && cur != prev_code) begin
        if (row_sel) begin
          chk(cur == seq_idx + 1, "R5", "window order", cur, seq_idx + 1);
          chk(idle_len == ((cur == 5) ? 0 : m_gw), (cur == 5) ? "R8" : "R6",
              "idle before strobe", idle_len, (cur == 5) ? 0 : m_gw);
          seq_idx++;
        end else begin
          chk(cur == 1, "R3", "only transfer outside window", cur, 1);
          pre_cnt++;
          if (pre_cnt > 1) chk(idle_len == m_iw, "R4", "pre-transfer spacing", idle_len, m_iw);
          if (rowgap_flag) begin
            chk(rowgap_cnt == m_gw, "R9", "row gap", rowgap_cnt, m_gw);
            rowgap_flag = 0;
          end
        end
      end
      // select fall
      if (!row_sel && prev_sel) begin
        chk(seq_idx == 5, "R5", "window strobes complete", seq_idx, 5);
        chk(col_done == 1'b1, "R8", "deselect only after done", col_done, 1);
        chk(wait_cnt == lat, "R8", "held until done", wait_cnt, lat);
        rows_seen++;
        exp_row++;
        pre_cnt = 0;
        rowgap_flag = 1;
        rowgap_cnt = 0;
      end
      if (rowgap_flag && !row_sel && cur == 0) rowgap_cnt++;
      if (frame_done) begin
        done_cnt++;
        chk(rows_seen == ROWS, "R10", "rows before frame done", rows_seen, ROWS);
        chk(!row_sel, "R10", "deselected at frame done", row_sel, 0);
        rowgap_flag = 0;
      end
      run_len  = (cur != 0 && cur == prev_code) ? run_len + 1 : ((cur != 0) ? 1 : 0);
      idle_len = (cur == 0) ? idle_len + 1 : 0;
      if (row_sel && seq_idx == 5 && cur != 5) wait_cnt++;
      if (cur == 5) wait_cnt = 0;
      prev_code = cur;
      prev_sel  = row_sel;
      prev_row  = row_idx;
    end
    // readout responder
    if (col_start) begin
      if (lat == 0) col_done <= 1'b1;
      else begin col_done <= 1'b0; end
    end else if (row_sel && seq_idx == 5 && wait_cnt == lat && lat > 0 && !col_done) begin
      col_done <= 1'b1;
    end else begin
      col_done <= 1'b0;
    end
  end

  task automatic mon_clear();
    prev_code = 0; run_len = 0; idle_len = 0; seq_idx = 0; pre_cnt = 0;
    exp_row = 0; rows_seen = 0; rowgap_cnt = 0; rowgap_flag = 0; done_cnt = 0;
    wait_cnt = 0; prev_sel = 0; prev_row = '0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start, frame_done} == 7'd0,
        "R1", "outputs in reset", {row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start, frame_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start, frame_done} == 7'd0,
        "R1", "outputs idle after reset", {row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start, frame_done}, 0);
    chk(row_idx == 0, "R1", "row index after reset", row_idx, 0);
  endtask

  // one frame; disturb pulses frame_start and changes the inputs mid-frame (R11, R12)
  task automatic run_frame(input int n_in, input int pw, input int gw, input int iw,
                           input int latency, input bit disturb);
    int guard;
    mon_clear();
    lat  = latency;
    m_n  = (n_in == 0) ? 1 : n_in;
    m_pw = (pw == 0) ? 1 : pw;
    m_gw = (gw == 0) ? 1 : gw;
    m_iw = (iw == 0) ? 1 : iw;
    xfer_count = 2'(n_in); pulse_len = TW'(pw); strobe_gap = TW'(gw); xfer_gap = TW'(iw);
    mon_en = 1;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (disturb && guard == 25) begin
        frame_start = 1'b1;
        xfer_count = 2'(m_n == 3 ? 1 : 3);
        pulse_len = TW'(m_pw + 2); strobe_gap = TW'(m_gw + 1); xfer_gap = TW'(m_iw + 3);
      end
      if (disturb && guard == 26) frame_start = 1'b0;
    end
    chk(done_cnt == 1, "R10", "frame done seen once", done_cnt, 1);
    chk(rows_seen == ROWS, "R2", "rows in frame", rows_seen, ROWS);
    repeat (12) @(negedge clk);
    chk({row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start} == 6'd0 && done_cnt == 1,
        "R10", "idle after frame", {row_sel, xfer_gate, sig_sample, pix_reset, rst_sample, col_start}, 0);
    mon_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lat = 1;
    t_reset_state();                 // R1
    run_frame(1, 2, 1, 1, 1, 0);     // R5 R6 R7 single transfer
    run_frame(2, 1, 2, 3, 2, 0);     // R3 R4 two transfers
    run_frame(3, 3, 1, 2, 4, 0);     // R3 R4 R9 three transfers
    run_frame(3, 1, 1, 1, 0, 0);     // R8 done in the start clock
    run_frame(0, 0, 0, 0, 3, 0);     // R3 R7 code 0 treated as 1
    run_frame(2, 2, 2, 1, 1, 1);     // R11 R12 mid-frame start and changes
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule